// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block drives an external bus whose 16 lines carry address and data at different times. A requester presents one transfer at a time: an address, write data, a read/write flag and a width select. The controller then runs a two-phase bus cycle. During the first phase it raises an address-latch strobe and places high-order address bits on the lines, so that an external latch can hold them. During the second phase the strobe is low. In this phase the lines carry the remaining address bits together with the write data, or the data lanes are released and read data is sampled from them.

Two width modes exist. In wide mode a 16-bit address is latched and then a full 16-bit word moves. In narrow mode the address is 24 bits. The top two address bytes go out during the strobe phase. The lowest address byte then travels on the upper lane while a byte of data uses the lower lane.

A system-level disable input takes the lines away from the bus engine. When it is set, four group-enable bits can each give four lines to a general-purpose flag function. The flag numbering swaps the two lanes: the upper lane carries flags 0 to 7 and the lower lane carries flags 8 to 15.

Top module: `muxbus_ctrl`

## Requirements
- R1: In narrow mode (`req_wide`=0), the address phase drives `ad_out[15:8]`=addr[23:16] and `ad_out[7:0]`=addr[15:8], with `ad_oe`=16'hFFFF.
- R2: In a narrow write, the data phase drives `ad_out[15:8]`=addr[7:0] and `ad_out[7:0]`=wdata[7:0], with `ad_oe`=16'hFFFF.
- R3: In wide mode (`req_wide`=1), the address phase drives addr[15:0] on all lines. A wide write's data phase drives wdata[15:0]. Both phases use `ad_oe`=16'hFFFF.
- R4: A request is accepted on a clock edge while the block is idle. From the next cycle, `ale` is high for max(`addr_len`,1) cycles. It is then low for max(`data_len`,1) cycles while `busy` stays high. The address phase always comes first.
- R5: `busy` is high from the cycle after acceptance until the data phase ends. A request presented while `busy` is high is ignored.
- R6: On a read, the data phase releases the data lanes. In wide mode this is `ad_oe`=16'h0000. In narrow mode it is `ad_oe`=16'hFF00, with addr[7:0] still on the upper lane. The lines are sampled on the last data-phase cycle. In the following cycle `rd_valid` pulses for exactly one cycle with `rd_data` set to the wide word, or to {8'h00, lower lane} in narrow mode.
- R7: A request made while `port_off`=1 is refused. `req_err` pulses for one cycle in the next cycle, and neither `ale` nor `busy` rises.
- R8: While `port_off`=1, bit g of `flag_grp_en` gives flags 4g..4g+3 to the flag function. Flag f uses line (f+8) mod 16, and drives `flag_out[f]` when `flag_dir[f]`=1. Lines not given away are released, with out=0 and oe=0.
- R9: `flag_in[f]` always equals `ad_in[(f+8) mod 16]`.
- R10: While `port_off`=0, `flag_grp_en` has no effect, and an idle port leaves all lines released.
- R11: After reset the block is idle. `busy`, `ale`, `req_err` and `rd_valid` are 0, and `ad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit mode, 0 = 8-bit mode |
| req_addr | input | 24 | Transfer address |
| req_wdata | input | 16 | Write data |
| addr_len | input | 4 | Address phase length in cycles (0 acts as 1) |
| data_len | input | 4 | Data phase length in cycles (0 acts as 1) |
| port_off | input | 1 | Disables the bus engine, pins go to flag logic |
| flag_grp_en | input | 4 | Per-group handover of flag pins |
| flag_out | input | 16 | Flag output values |
| flag_dir | input | 16 | Flag direction, 1 = drive |
| flag_in | output | 16 | Flag input values |
| busy | output | 1 | Cycle in progress |
| ale | output | 1 | Address latch strobe |
| req_err | output | 1 | Refused-request pulse |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Captured read data |
| ad_in | input | 16 | Line input values |
| ad_out | output | 16 | Line output values |
| ad_oe | output | 16 | Line output enables |

## Verification
The checker watches several rules on every cycle. The strobe never appears outside a busy cycle. Every cycle opens with the strobe phase, and the data phase follows the strobe unless the port is switched off. A refused request never coincides with a busy cycle, and read-valid lasts one cycle. The checker also confirms that lines are released on wide reads, while idle, and when the port is off with no group handed over. The correctness of the lane contents, the exact phase lengths, the captured read values and the flag-to-line swap are shown only by the bench's directed scenarios, which compare against values worked out from the address, the data and the group bits.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/muxbus_seq.sv
module muxbus_seq
  import muxbus_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 24,
  parameter int PH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic [PH_W-1:0]   addr_len,
  input  logic [PH_W-1:0]   data_len,
  input  logic              port_off,
  input  logic [BUS_W-1:0]  ad_in,
  output phase_e            phase,
  output logic              cur_write,
  output logic              cur_wide,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [BUS_W-1:0]  cur_wdata,
  output logic              req_err,
  output logic              rd_valid,
  output logic [BUS_W-1:0]  rd_data
);
  localparam int LANE_W = BUS_W / 2;

  phase_e          state_q, state_d;
  logic [PH_W-1:0] cnt_q, cnt_d;
  logic            load_req, err_d, cap_d;
  logic [BUS_W-1:0] cap_val;

  function automatic logic [PH_W-1:0] span_m1(input logic [PH_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    load_req = 1'b0;
    err_d    = 1'b0;
    cap_d    = 1'b0;
    case (state_q)
      PH_IDLE: begin
        if (req_valid) begin
          if (port_off) begin
            err_d = 1'b1;
          end else begin
            state_d  = PH_ADDR;
            load_req = 1'b1;
            cnt_d    = span_m1(addr_len);
          end
        end
      end
      PH_ADDR: begin
        if (port_off) begin
          state_d = PH_IDLE;
        end else if (cnt_q == '0) begin
          state_d = PH_DATA;
          cnt_d   = span_m1(data_len);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_DATA: begin
        if (port_off) begin
          state_d = PH_IDLE;
        end else if (cnt_q == '0) begin
          state_d = PH_IDLE;
          cap_d   = ~cur_write;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  assign cap_val = cur_wide ? ad_in : {{LANE_W{1'b0}}, ad_in[LANE_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PH_IDLE;
      cnt_q    <= '0;
      req_err  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      req_err  <= err_d;
      rd_valid <= cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_write <= 1'b0;
      cur_wide  <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (load_req) begin
      cur_write <= req_write;
      cur_wide  <= req_wide;
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (cap_d) begin
      rd_data <= cap_val;
    end
  end

  assign phase = state_q;
endmodule

// File: rtl/muxbus_lane_mux.sv
module muxbus_lane_mux
  import muxbus_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 24
) (
  input  phase_e            phase,
  input  logic              cur_write,
  input  logic              cur_wide,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [BUS_W-1:0]  cur_wdata,
  output logic [BUS_W-1:0]  port_out,
  output logic [BUS_W-1:0]  port_oe
);
  localparam int LANE_W = BUS_W / 2;

  logic [LANE_W-1:0] a_hi, a_mid, a_lo;

  assign a_hi  = cur_addr[3*LANE_W-1:2*LANE_W];
  assign a_mid = cur_addr[2*LANE_W-1:LANE_W];
  assign a_lo  = cur_addr[LANE_W-1:0];

  always_comb begin
    port_out = '0;
    port_oe  = '0;
    case (phase)
      PH_ADDR: begin
        port_oe  = '1;
        port_out = cur_wide ? {a_mid, a_lo} : {a_hi, a_mid};
      end
      PH_DATA: begin
        if (cur_wide) begin
          port_out = cur_write ? cur_wdata : '0;
          port_oe  = cur_write ? '1 : '0;
        end else begin
          port_out = {a_lo, cur_write ? cur_wdata[LANE_W-1:0] : {LANE_W{1'b0}}};
          port_oe  = {{LANE_W{1'b1}}, {LANE_W{cur_write}}};
        end
      end
      default: begin
        port_out = '0;
        port_oe  = '0;
      end
    endcase
  end
endmodule

// File: rtl/muxbus_pin_arb.sv
module muxbus_pin_arb #(
  parameter int BUS_W  = 16,
  parameter int GRP_N  = 4
) (
  input  logic              port_off,
  input  logic [GRP_N-1:0]  flag_grp_en,
  input  logic [BUS_W-1:0]  port_out,
  input  logic [BUS_W-1:0]  port_oe,
  input  logic [BUS_W-1:0]  flag_out,
  input  logic [BUS_W-1:0]  flag_dir,
  input  logic [BUS_W-1:0]  ad_in,
  output logic [BUS_W-1:0]  ad_out,
  output logic [BUS_W-1:0]  ad_oe,
  output logic [BUS_W-1:0]  flag_in
);
  localparam int LANE_W  = BUS_W / 2;
  localparam int GRP_SZ  = BUS_W / GRP_N;

  for (genvar p = 0; p < BUS_W; p++) begin : g_pin
    localparam int FLG = (p + LANE_W) % BUS_W;
    localparam int GRP = FLG / GRP_SZ;
    logic handed;
    assign handed     = port_off & flag_grp_en[GRP];
    assign ad_oe[p]   = port_off ? (handed & flag_dir[FLG]) : port_oe[p];
    assign ad_out[p]  = port_off ? (handed & flag_dir[FLG] & flag_out[FLG]) : port_out[p];
    assign flag_in[FLG] = ad_in[p];
  end
endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 24,
  parameter int PH_W   = 4,
  parameter int GRP_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic [PH_W-1:0]   addr_len,
  input  logic [PH_W-1:0]   data_len,
  input  logic              port_off,
  input  logic [GRP_N-1:0]  flag_grp_en,
  input  logic [BUS_W-1:0]  flag_out,
  input  logic [BUS_W-1:0]  flag_dir,
  output logic [BUS_W-1:0]  flag_in,
  output logic              busy,
  output logic              ale,
  output logic              req_err,
  output logic              rd_valid,
  output logic [BUS_W-1:0]  rd_data,
  input  logic [BUS_W-1:0]  ad_in,
  output logic [BUS_W-1:0]  ad_out,
  output logic [BUS_W-1:0]  ad_oe
);
  phase_e            phase;
  logic              cur_write, cur_wide;
  logic [ADDR_W-1:0] cur_addr;
  logic [BUS_W-1:0]  cur_wdata;
  logic [BUS_W-1:0]  port_out, port_oe;

  muxbus_seq #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .PH_W(PH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .addr_len(addr_len), .data_len(data_len), .port_off(port_off),
    .ad_in(ad_in), .phase(phase), .cur_write(cur_write), .cur_wide(cur_wide),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata), .req_err(req_err),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  muxbus_lane_mux #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_mux (
    .phase(phase), .cur_write(cur_write), .cur_wide(cur_wide),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .port_out(port_out), .port_oe(port_oe)
  );

  muxbus_pin_arb #(.BUS_W(BUS_W), .GRP_N(GRP_N)) u_arb (
    .port_off(port_off), .flag_grp_en(flag_grp_en), .port_out(port_out),
    .port_oe(port_oe), .flag_out(flag_out), .flag_dir(flag_dir),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .flag_in(flag_in)
  );

  assign busy = (phase != PH_IDLE);
  assign ale  = (phase == PH_ADDR);
endmodule

// File: rtl/muxbus_chk.sv
module muxbus_chk #(
  parameter int BUS_W = 16,
  parameter int GRP_N = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             ale,
  input logic             req_err,
  input logic             rd_valid,
  input logic             port_off,
  input logic             cur_write,
  input logic             cur_wide,
  input logic [GRP_N-1:0] flag_grp_en,
  input logic [BUS_W-1:0] ad_oe
);
  // R4
  ale_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> busy);
  // R4
  start_with_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ale);
  // R4
  data_follows_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale) && !$past(port_off)) |-> busy);
  // R7
  refuse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!busy && !ale));
  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R6
  rd_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !busy);
  // R6
  wide_read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale && !cur_write && cur_wide && !port_off) |-> (ad_oe == '0));
  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !port_off) |-> (ad_oe == '0));
  // R8
  off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_off && flag_grp_en == '0) |-> (ad_oe == '0));
endmodule

bind muxbus_ctrl muxbus_chk #(.BUS_W(BUS_W), .GRP_N(GRP_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ale(ale), .req_err(req_err),
  .rd_valid(rd_valid), .port_off(port_off), .cur_write(cur_write),
  .cur_wide(cur_wide), .flag_grp_en(flag_grp_en), .ad_oe(ad_oe)
);

// File: tb/muxbus_ctrl_tb_top.sv
module muxbus_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req_valid, req_write, req_wide;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;
  logic [3:0]  addr_len, data_len;
  logic        port_off;
  logic [3:0]  flag_grp_en;
  logic [15:0] flag_out, flag_dir, flag_in;
  logic        busy, ale, req_err, rd_valid;
  logic [15:0] rd_data, ad_in, ad_out, ad_oe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  muxbus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .addr_len(addr_len), .data_len(data_len), .port_off(port_off),
    .flag_grp_en(flag_grp_en), .flag_out(flag_out), .flag_dir(flag_dir),
    .flag_in(flag_in), .busy(busy), .ale(ale), .req_err(req_err),
    .rd_valid(rd_valid), .rd_data(rd_data), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_cycle(input bit wr, input bit wide, input logic [23:0] a,
                           input logic [15:0] d, input logic [3:0] al,
                           input logic [3:0] dl, input logic [15:0] rin);
    int ea, ed, na, nd;
    bit seen_data, order_ok;
    logic [15:0] x_addr, x_data, x_doe, x_rd;
    ea = (al == 0) ? 1 : int'(al);
    ed = (dl == 0) ? 1 : int'(dl);
    x_addr = wide ? a[15:0] : {a[23:16], a[15:8]};
    if (wide) begin
      x_data = wr ? d : 16'h0000;
      x_doe  = wr ? 16'hFFFF : 16'h0000;
      x_rd   = rin;
    end else begin
      x_data = {a[7:0], wr ? d[7:0] : 8'h00};
      x_doe  = wr ? 16'hFFFF : 16'hFF00;
      x_rd   = {8'h00, rin[7:0]};
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = a;
    req_wdata = d; addr_len = al; data_len = dl; ad_in = rin;
    @(negedge clk);
    req_valid = 1'b0;
    na = 0; nd = 0; seen_data = 0; order_ok = 1;
    for (int i = 0; i < 64 && busy; i++) begin
      if (ale) begin
        na++;
        if (seen_data) order_ok = 0;
        check(ad_out == x_addr && ad_oe == 16'hFFFF, wide ? "R3 addr lanes" : "R1 addr lanes",
              {ad_out, ad_oe}, {x_addr, 16'hFFFF});
      end else begin
        nd++;
        seen_data = 1;
        check((ad_out & x_doe) == x_data && ad_oe == x_doe,
              wide ? "R3/R6 data lanes" : "R2/R6 data lanes",
              {ad_out & x_doe, ad_oe}, {x_data, x_doe});
      end
      @(negedge clk);
    end
    check(na == ea, "R4 addr phase length", na, ea);
    check(nd == ed, "R4 data phase length", nd, ed);
    check(order_ok, "R4 phase order", order_ok, 1);
    if (!wr) begin
      check(rd_valid == 1'b1 && rd_data == x_rd, "R6 read capture",
            {15'b0, rd_valid, rd_data}, {16'h0001, x_rd});
      @(negedge clk);
      check(rd_valid == 1'b0, "R6 rd_valid one cycle", rd_valid, 0);
    end else begin
      check(rd_valid == 1'b0, "R6 no rd_valid on write", rd_valid, 0);
    end
  endtask

  task automatic t_reset();
    check(busy == 0 && ale == 0 && req_err == 0 && rd_valid == 0 && ad_oe == 0,
          "R11 reset state", {busy, ale, req_err, rd_valid, 12'b0, ad_oe}, 0);
  endtask

  task automatic t_narrow_write();
    run_cycle(1'b1, 1'b0, 24'hA1B2C3, 16'h005D, 4'd2, 4'd3, 16'h0000);
  endtask

  task automatic t_wide_write();
    run_cycle(1'b1, 1'b1, 24'h009876, 16'hBEEF, 4'd1, 4'd1, 16'h0000);
    run_cycle(1'b1, 1'b1, 24'h00135A, 16'h7001, 4'd0, 4'd0, 16'h0000);
  endtask

  task automatic t_reads();
    run_cycle(1'b0, 1'b1, 24'h004400, 16'h0000, 4'd1, 4'd2, 16'h4C21);
    run_cycle(1'b0, 1'b0, 24'h3C2B1A, 16'h0000, 4'd3, 4'd1, 16'h7E93);
  endtask

  task automatic t_busy_ignore();
    int nb;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_wide = 1; req_addr = 24'h001111;
    req_wdata = 16'h2222; addr_len = 1; data_len = 1;
    @(negedge clk);
    req_addr = 24'h00FFFF;
    check(ale && ad_out == 16'h1111, "R5 first request addr", ad_out, 16'h1111);
    @(negedge clk);
    req_valid = 0;
    check(busy && !ale && ad_out == 16'h2222, "R5 second request ignored", ad_out, 16'h2222);
    nb = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (busy) nb++;
    end
    check(nb == 0, "R5 no extra cycle", nb, 0);
  endtask

  task automatic t_refuse();
    @(negedge clk);
    port_off = 1; flag_grp_en = 0; req_valid = 1; req_write = 1; req_wide = 1;
    @(negedge clk);
    req_valid = 0;
    check(req_err && !busy && !ale, "R7 refuse pulse", {req_err, busy, ale}, 3'b100);
    @(negedge clk);
    check(!req_err && !busy && !ale, "R7 pulse ends", {req_err, busy, ale}, 3'b000);
    port_off = 0;
  endtask

  task automatic t_flags();
    @(negedge clk);
    port_off = 1; flag_grp_en = 4'b0101; flag_out = 16'hA5C3;
    flag_dir = 16'hFFFF; ad_in = 16'h1234;
    #1;
    check(ad_oe == 16'h0F0F, "R8 handed pins oe", ad_oe, 16'h0F0F);
    check(ad_out == 16'h0305, "R8 handed pins values", ad_out, 16'h0305);
    check(flag_in == 16'h3412, "R9 flag inputs swapped", flag_in, 16'h3412);
    flag_dir = 16'h0F00;
    #1;
    check(ad_oe == 16'h000F && ad_out == 16'h0005, "R8 flag direction",
          {ad_oe, ad_out}, {16'h000F, 16'h0005});
    port_off = 0; flag_dir = 16'hFFFF; flag_grp_en = 4'b1111;
    #1;
    check(ad_oe == 16'h0000 && ad_out == 16'h0000, "R10 groups ignored when on",
          {ad_oe, ad_out}, 0);
    flag_grp_en = 0;
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_wide = 0; req_addr = 0;
    req_wdata = 0; addr_len = 0; data_len = 0; port_off = 0; flag_grp_en = 0;
    flag_out = 0; flag_dir = 0; ad_in = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_narrow_write();
    t_wide_write();
    t_reads();
    t_busy_ignore();
    t_refuse();
    t_flags();
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule